// File: doc/BRIEF.md
# Instruction Fetch Loop Buffer

This block sits next to an instruction fetch stage and keeps the words that stage most recently brought in from memory, each stored with its complete address. Each fetch request is looked up in this small store before anything reaches the memory side. A hit is answered in the same cycle from the store, and memory sees no request. A miss is accepted at once and sent to memory as a single-word read. The word that comes back is passed through to the fetch stage and also written into the store, replacing entries in strict rotation. Tight loops and short backward jumps therefore run out of the store after their first pass.

Four valid/ready channels carry the data: fetch request, fetch response, memory request and memory response. A transfer happens on a clock edge where both valid and ready are high. A source keeps valid high and its payload unchanged until that transfer. On a hit, the fetch request is accepted in the same cycle as the response transfer, so back-pressure on the fetch response stalls the request. On a miss, back-pressure on the fetch response is passed straight through to the memory response channel. Only one memory read is outstanding at a time. A plain `flush` pulse invalidates every entry in one cycle. Only the fill path writes the store. If two entries ever hold the same address, the one written most recently answers.

Top module: `fetch_loop_buf`

## Requirements
- R1: After reset every entry is invalid: no fetch response or memory request is pending, `fetch_req_ready` is high while idle, and the first fetch of any address is a miss.
- R2: A fetch whose address is held in a valid entry is answered in the request cycle: `fetch_rsp_valid` is high and `fetch_rsp_data` is the stored word.
- R3: A hit issues no memory request: `mem_req_valid` stays low during and after the hit transfer.
- R4: A miss is accepted in its request cycle with no response. In the next cycle `mem_req_valid` rises with `mem_req_addr` equal to the fetch address, and both are held until `mem_req_ready`.
- R5: From the accepted miss until its memory response transfers, `fetch_req_ready` is low. At most one memory read is outstanding.
- R6: While a miss waits for its response, `fetch_rsp_valid` follows `mem_rsp_valid`, `fetch_rsp_data` carries `mem_rsp_data`, and `mem_rsp_ready` follows `fetch_rsp_ready`.
- R7: Each filled word goes into the next slot in rotation 0, 1, …, N-1, 0. With N=8, after eight distinct fills the next miss evicts the oldest address, and the other seven still hit.
- R8: A `flush` pulse invalidates all entries in one cycle, so the next fetch of any address misses. The rotation restarts at slot 0. A hit transferring in the flush cycle is still delivered.
- R9: When `flush` is high in the cycle the miss response transfers, the word still reaches the fetch stage but is not kept. A later fetch of that address misses again.
- R10: On a hit with `fetch_rsp_ready` low, `fetch_req_ready` is low, and the response stays valid with unchanged data while the request is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Invalidate all entries |
| fetch_req_valid | input | 1 | Fetch request valid |
| fetch_req_ready | output | 1 | Fetch request accepted |
| fetch_req_addr | input | AW | Instruction address |
| fetch_rsp_valid | output | 1 | Fetch response valid |
| fetch_rsp_ready | input | 1 | Fetch stage can take the response |
| fetch_rsp_data | output | DW | Instruction word |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Memory read address |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_ready | output | 1 | Block takes the read data |
| mem_rsp_data | input | DW | Memory read data |

## Verification
Two events can land in the same cycle: an invalidation, and either a store write or a store read. The bench drives `flush` during the transfer of a miss response and also during the transfer of a hit. It then checks two things. The fetch stage still got the correct word in that cycle. A repeat fetch of the same address is now a miss that goes to memory. Around these cases, a reference model follows the rotation through a long sweep of repeating addresses, with varied memory latency and back-pressure. That model decides for every fetch whether it must be answered in the request cycle.

// File: rtl/lbuf_pkg.sv
package lbuf_pkg;
  typedef enum logic [1:0] {
    LB_IDLE = 2'd0,
    LB_SEND = 2'd1,
    LB_WAIT = 2'd2
  } lb_state_e;
endpackage

// File: rtl/lbuf_store.sv
module lbuf_store #(
  parameter int N  = 8,
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [AW-1:0] look_addr,
  output logic          look_hit,
  output logic [DW-1:0] look_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;
  localparam logic [PW-1:0] LAST = PW'(N - 1);

  logic [N-1:0]  ent_v;
  logic [AW-1:0] ent_tag  [N];
  logic [DW-1:0] ent_word [N];
  logic [N-1:0]  ent_match;
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] sel;

  // One slot per generate iteration: storage and comparator
  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_v[g]    <= 1'b0;
        ent_tag[g]  <= '0;
        ent_word[g] <= '0;
      end else if (flush) begin
        ent_v[g] <= 1'b0;
      end else if (wr_en && wr_ptr == PW'(g)) begin
        ent_v[g]    <= 1'b1;
        ent_tag[g]  <= wr_addr;
        ent_word[g] <= wr_data;
      end
    end
    assign ent_match[g] = ent_v[g] && (ent_tag[g] == look_addr);
  end

  // Rotation pointer: restarts at slot 0 on flush
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wr_ptr <= '0;
    else if (flush) wr_ptr <= '0;
    else if (wr_en) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
  end

  // Search newest-first: the slot just before wr_ptr was written last
  always_comb begin
    look_hit = 1'b0;
    sel      = '0;
    for (int i = 0; i < N; i++) begin
      int j;
      j = (int'(wr_ptr) + N - 1 - i) % N;
      if (!look_hit && ent_match[j]) begin
        look_hit = 1'b1;
        sel      = PW'(j);
      end
    end
  end

  assign look_data = ent_word[sel];
endmodule

// File: rtl/lbuf_ctrl.sv
module lbuf_ctrl
  import lbuf_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_req_valid,
  output logic          fetch_req_ready,
  input  logic [AW-1:0] fetch_req_addr,
  output logic          fetch_rsp_valid,
  input  logic          fetch_rsp_ready,
  input  logic          look_hit,
  output logic          from_mem,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  output logic          mem_rsp_ready,
  output logic          fill_en,
  output logic [AW-1:0] fill_addr
);
  lb_state_e     state, state_nx;
  logic [AW-1:0] miss_addr;
  logic          miss_take;

  always_comb begin
    state_nx        = state;
    fetch_req_ready = 1'b0;
    fetch_rsp_valid = 1'b0;
    mem_req_valid   = 1'b0;
    mem_rsp_ready   = 1'b0;
    from_mem        = 1'b0;
    fill_en         = 1'b0;
    miss_take       = 1'b0;
    unique case (state)
      LB_IDLE: begin
        if (fetch_req_valid && look_hit) begin
          fetch_rsp_valid = 1'b1;
          fetch_req_ready = fetch_rsp_ready;
        end else begin
          fetch_req_ready = 1'b1;
          if (fetch_req_valid) begin
            miss_take = 1'b1;
            state_nx  = LB_SEND;
          end
        end
      end
      LB_SEND: begin
        mem_req_valid = 1'b1;
        if (mem_req_ready) state_nx = LB_WAIT;
      end
      LB_WAIT: begin
        from_mem        = 1'b1;
        fetch_rsp_valid = mem_rsp_valid;
        mem_rsp_ready   = fetch_rsp_ready;
        if (mem_rsp_valid && fetch_rsp_ready) begin
          fill_en  = 1'b1;
          state_nx = LB_IDLE;
        end
      end
      default: state_nx = LB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= LB_IDLE;
      miss_addr <= '0;
    end else begin
      state <= state_nx;
      if (miss_take) miss_addr <= fetch_req_addr;
    end
  end

  assign mem_req_addr = miss_addr;
  assign fill_addr    = miss_addr;
endmodule

// File: rtl/fetch_loop_buf.sv
module fetch_loop_buf #(
  parameter int N  = 8,
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          fetch_req_valid,
  output logic          fetch_req_ready,
  input  logic [AW-1:0] fetch_req_addr,
  output logic          fetch_rsp_valid,
  input  logic          fetch_rsp_ready,
  output logic [DW-1:0] fetch_rsp_data,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  output logic          mem_rsp_ready,
  input  logic [DW-1:0] mem_rsp_data
);
  logic          look_hit;
  logic [DW-1:0] look_data;
  logic          from_mem;
  logic          fill_en;
  logic [AW-1:0] fill_addr;

  lbuf_store #(.N(N), .AW(AW), .DW(DW)) store_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .look_addr (fetch_req_addr),
    .look_hit  (look_hit),
    .look_data (look_data),
    .wr_en     (fill_en),
    .wr_addr   (fill_addr),
    .wr_data   (mem_rsp_data)
  );

  lbuf_ctrl #(.AW(AW)) ctrl_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .fetch_req_valid (fetch_req_valid),
    .fetch_req_ready (fetch_req_ready),
    .fetch_req_addr  (fetch_req_addr),
    .fetch_rsp_valid (fetch_rsp_valid),
    .fetch_rsp_ready (fetch_rsp_ready),
    .look_hit        (look_hit),
    .from_mem        (from_mem),
    .mem_req_valid   (mem_req_valid),
    .mem_req_ready   (mem_req_ready),
    .mem_req_addr    (mem_req_addr),
    .mem_rsp_valid   (mem_rsp_valid),
    .mem_rsp_ready   (mem_rsp_ready),
    .fill_en         (fill_en),
    .fill_addr       (fill_addr)
  );

  assign fetch_rsp_data = from_mem ? mem_rsp_data : look_data;
endmodule

// File: rtl/fetch_loop_buf_chk.sv
module fetch_loop_buf_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          fetch_req_valid,
  input logic          fetch_req_ready,
  input logic          fetch_rsp_valid,
  input logic          fetch_rsp_ready,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          mem_rsp_valid,
  input logic          mem_rsp_ready,
  input logic          look_hit
);
  logic in_flight;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                in_flight <= 1'b0;
    else if (mem_rsp_valid && mem_rsp_ready)   in_flight <= 1'b0;
    else if (mem_req_valid && mem_req_ready)   in_flight <= 1'b1;
  end

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R3
  hit_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req_valid && fetch_req_ready && fetch_rsp_valid && fetch_rsp_ready |=> !mem_req_valid);

  // R5
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_flight && mem_req_valid));

  // R5
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || in_flight) |-> !fetch_req_ready);

  // R6
  rsp_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid && mem_rsp_ready |-> fetch_rsp_valid && fetch_rsp_ready);

  // R8
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !look_hit);
endmodule

bind fetch_loop_buf fetch_loop_buf_chk #(.AW(AW)) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .flush           (flush),
  .fetch_req_valid (fetch_req_valid),
  .fetch_req_ready (fetch_req_ready),
  .fetch_rsp_valid (fetch_rsp_valid),
  .fetch_rsp_ready (fetch_rsp_ready),
  .mem_req_valid   (mem_req_valid),
  .mem_req_ready   (mem_req_ready),
  .mem_req_addr    (mem_req_addr),
  .mem_rsp_valid   (mem_rsp_valid),
  .mem_rsp_ready   (mem_rsp_ready),
  .look_hit        (look_hit)
);

// File: tb/fetch_loop_buf_tb_top.sv
module fetch_loop_buf_tb_top;
  localparam int N  = 8;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flush = 1'b0;
  logic          fetch_req_valid = 1'b0;
  logic          fetch_req_ready;
  logic [AW-1:0] fetch_req_addr = '0;
  logic          fetch_rsp_valid;
  logic          fetch_rsp_ready = 1'b1;
  logic [DW-1:0] fetch_rsp_data;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic          mem_rsp_valid = 1'b0;
  logic          mem_rsp_ready;
  logic [DW-1:0] mem_rsp_data = '0;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // reference model of slot contents
  logic [AW-1:0] m_tag [N];
  bit            m_v   [N];
  int            m_ptr = 0;

  always #5 clk = ~clk;

  fetch_loop_buf #(.N(N), .AW(AW), .DW(DW)) dut_i (.*);

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit m_hit(input logic [AW-1:0] a);
    for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == a) return 1'b1;
    return 1'b0;
  endfunction

  task automatic m_clear();
    for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    m_ptr = 0;
  endtask

  // One fetch; lat = cycles mem_req_ready stays low, bp = one cycle of rsp back-pressure,
  // fl = flush during the response transfer
  task automatic fetch(input logic [AW-1:0] a, input int lat, input bit bp, input bit fl, input string tag);
    bit exp_hit;
    exp_hit = m_hit(a);
    @(negedge clk);
    fetch_req_valid = 1'b1;
    fetch_req_addr  = a;
    fetch_rsp_ready = !bp;
    #1;
    chk(fetch_rsp_valid == exp_hit, tag, 32'(fetch_rsp_valid), 32'(exp_hit));
    if (exp_hit) begin
      chk(fetch_rsp_data == mem_word(a), "R2", fetch_rsp_data, mem_word(a));
      chk(!mem_req_valid, "R3", 32'(mem_req_valid), 0);
      if (bp) begin
        chk(!fetch_req_ready, "R10", 32'(fetch_req_ready), 0);
        @(negedge clk);
        fetch_rsp_ready = 1'b1;
        #1;
        chk(fetch_rsp_valid && fetch_rsp_data == mem_word(a), "R10", fetch_rsp_data, mem_word(a));
        chk(fetch_req_ready, "R10", 32'(fetch_req_ready), 1);
      end
      flush = fl;
      @(negedge clk);
      fetch_req_valid = 1'b0;
      flush = 1'b0;
      #1;
      chk(!mem_req_valid, "R3", 32'(mem_req_valid), 0);
      if (fl) m_clear();
    end else begin
      if (!fetch_rsp_valid) chk(fetch_req_ready, "R4", 32'(fetch_req_ready), 1);
      @(negedge clk);
      fetch_req_valid = 1'b0;
      fetch_rsp_ready = 1'b1;
      mem_req_ready   = (lat == 0);
      #1;
      chk(mem_req_valid && mem_req_addr == a, "R4", mem_req_addr, a);
      chk(!fetch_req_ready, "R5", 32'(fetch_req_ready), 0);
      for (int c = 0; c < lat; c++) begin
        @(negedge clk);
        if (c == lat - 1) mem_req_ready = 1'b1;
        #1;
        chk(mem_req_valid && mem_req_addr == a, "R4", mem_req_addr, a);
      end
      @(negedge clk);
      mem_req_ready   = 1'b0;
      mem_rsp_valid   = 1'b1;
      mem_rsp_data    = mem_word(a);
      fetch_rsp_ready = !bp;
      #1;
      chk(!mem_req_valid, "R5", 32'(mem_req_valid), 0);
      chk(fetch_rsp_valid && fetch_rsp_data == mem_word(a), "R6", fetch_rsp_data, mem_word(a));
      chk(mem_rsp_ready == !bp, "R6", 32'(mem_rsp_ready), 32'(!bp));
      if (bp) begin
        chk(!fetch_req_ready, "R5", 32'(fetch_req_ready), 0);
        @(negedge clk);
        fetch_rsp_ready = 1'b1;
        #1;
        chk(mem_rsp_ready, "R6", 32'(mem_rsp_ready), 1);
      end
      flush = fl;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      flush = 1'b0;
      #1;
      chk(!fetch_rsp_valid && fetch_req_ready, "R5", 32'(fetch_rsp_valid), 0);
      if (fl) m_clear();
      else begin
        m_tag[m_ptr] = a;
        m_v[m_ptr]   = 1'b1;
        m_ptr        = (m_ptr + 1) % N;
      end
    end
  endtask

  initial begin
    m_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!fetch_rsp_valid, "R1", 32'(fetch_rsp_valid), 0);
    chk(!mem_req_valid, "R1", 32'(mem_req_valid), 0);
    chk(fetch_req_ready, "R1", 32'(fetch_req_ready), 1);

    // fill every slot, then hit them all
    for (int i = 0; i < N; i++) fetch(32'h100 + 32'(4 * i), i % 3, i[0], 1'b0, "R1");
    for (int i = 0; i < N; i++) fetch(32'h100 + 32'(4 * i), 0, i[0], 1'b0, "R2");
    // one more distinct fill evicts the oldest address
    fetch(32'h200, 1, 1'b0, 1'b0, "R7");
    for (int i = 1; i < N; i++) fetch(32'h100 + 32'(4 * i), 0, 1'b0, 1'b0, "R7");
    fetch(32'h100, 0, 1'b0, 1'b0, "R7");

    // sweep over a repeating address pattern wider than the store
    for (int k = 0; k < 60; k++)
      fetch(32'h400 + 32'(4 * ((k * 5) % 11)), k % 3, k[0], 1'b0, "R7");
    for (int k = 0; k < 40; k++)
      fetch(32'h800 + 32'(4 * (k % 7)), k % 2, k[1], 1'b0, "R2");

    // idle flush
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    m_clear();
    fetch(32'h800, 0, 1'b0, 1'b0, "R8");
    for (int i = 0; i < N + 2; i++) fetch(32'hA00 + 32'(4 * i), 1, 1'b0, 1'b0, "R8");
    fetch(32'hA00 + 32'(4 * (N + 1)), 0, 1'b0, 1'b0, "R8");

    // flush coinciding with a hit transfer
    fetch(32'hA00 + 32'(4 * (N + 1)), 0, 1'b1, 1'b1, "R8");
    fetch(32'hA00 + 32'(4 * (N + 1)), 0, 1'b0, 1'b0, "R8");

    // flush coinciding with a fill transfer
    fetch(32'hC00, 2, 1'b0, 1'b1, "R9");
    fetch(32'hC00, 0, 1'b1, 1'b1, "R9");
    fetch(32'hC00, 1, 1'b0, 1'b0, "R9");
    fetch(32'hC00, 0, 1'b0, 1'b0, "R9");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule